// File: doc/BRIEF.md
# Banked Program and Pattern Address Mapper

This block sits between a CPU bus, a video pattern fetch bus and the cartridge memories. It turns a CPU address in the `$6000-$FFFF` space into either a work-RAM access or a program-ROM address built from an 8 KB bank number. It turns a 13-bit pattern address (`$0000-$1FFF`) into a pattern-memory address built from a 1 KB bank number. It also drives the nametable mirroring choice.

Eight bank registers, here called slots 0 to 7, hold the bank numbers. A control pair at `$8000-$9FFF` loads them. An even address there writes the slot pointer and the two layout bits. An odd address writes data into the slot that the pointer names. A second pair at `$A000-$BFFF` holds the mirroring bit (even address) and the work-RAM enable and write-lock bits (odd address).

The two layout bits swap the switchable program window with the fixed second-last one. They also swap the two halves of the pattern space. The block is purely a mapper: it holds no interrupt logic and no memories. Its outputs are combinational from the registered state and the current addresses.

Top module: `pgm_bank_mapper`

## Requirements
- R1: After reset all bank slots, the slot pointer and both layout bits are zero, mirroring is vertical (`mirror_horiz`=0), and work RAM is disabled.
- R2: On a write cycle, `$8000-$9FFF` is decoded by address bit 0. An even address loads the slot pointer from data bits 2:0, and an odd address loads the slot that the pointer names. Any even or odd address in the window behaves the same.
- R3: With the program layout bit (pointer-write bit 6) at 0, `$8000-$9FFF` maps the bank in slot 6 and `$C000-$DFFF` maps bank `PRG_BANKS-2`.
- R4: With the program layout bit at 1, those two windows swap: `$8000-$9FFF` maps bank `PRG_BANKS-2` and `$C000-$DFFF` maps slot 6.
- R5: `$A000-$BFFF` always maps slot 7 and `$E000-$FFFF` always maps bank `PRG_BANKS-1`. The program address is bank*8192 + the address bits 12:0.
- R6: Slots 6 and 7 keep only data bits 5:0, so bits 7:6 written to them have no effect.
- R7: With the pattern layout bit (pointer-write bit 7) at 0, `$0000-$07FF` and `$0800-$0FFF` map 2 KB banks from slots 0 and 1. `$1000-$1FFF` maps four 1 KB banks from slots 2, 3, 4 and 5 in ascending order. The pattern address is bank*1024 + address bits 9:0.
- R8: With the pattern layout bit at 1, the `$0000-$0FFF` and `$1000-$1FFF` halves swap their bank sources.
- R9: Slots 0 and 1 drop data bit 0. In a 2 KB window, pattern address bit 10 supplies bit 10 of the output.
- R10: Data bit 0 written to an even address in `$A000-$BFFF` drives `mirror_horiz` (0 vertical, 1 horizontal).
- R11: Data bit 7 written to an odd address in `$A000-$BFFF` enables work RAM. An access to `$6000-$7FFF` raises `ram_ce` when RAM is enabled and `open_bus` when it is not. Neither is raised outside that range.
- R12: Data bit 6 of that same register locks writes. `ram_we` is high only on a write cycle to `$6000-$7FFF` with RAM enabled and the lock clear.
- R13: Write cycles to `$6000-$7FFF`, `$C000-$FFFF` or below `$6000` leave all mapping state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 13 | Pattern fetch address |
| prg_addr | output | log2(PRG_BANKS)+13 | Program ROM address (meaningful for `$8000-$FFFF`) |
| chr_addr | output | 18 | Pattern memory address |
| ram_ce | output | 1 | Work RAM selected and enabled |
| ram_we | output | 1 | Work RAM write enable |
| open_bus | output | 1 | Access to disabled work RAM |
| mirror_horiz | output | 1 | Nametable mirroring: 1 horizontal, 0 vertical |

## Verification
The properties assume that `cpu_wr` is a single-cycle strobe and that address and data stay steady across the rising edge that captures them. They also assume `PRG_BANKS` is a power of two, so the last bank number is all ones. The stimulus changes every input only at the falling edge and raises `cpu_wr` for exactly one rising edge per write. Pattern and CPU read addresses are applied with the strobe low, so the mapping and RAM-select outputs are sampled in a settled state. Reads are never mixed with register writes in the same cycle.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int BANK_W     = 8;   // width of a pattern slot
    localparam int PRG_SLOT_W = 6;   // width kept by program slots 6 and 7
    localparam int CHR_SLOTS  = 6;   // slots 0..5 feed the pattern side
    localparam int CHR_AW     = BANK_W + 10;

    // CPU space decoded on address bits 15:13
    typedef enum logic [2:0] {
        RGN_WRAM  = 3'b011,
        RGN_BANK  = 3'b100,
        RGN_LAYOUT = 3'b101
    } cpu_region_e;

    typedef struct packed {
        logic [2:0]                          slot_ptr;
        logic                                prg_swap;
        logic                                chr_swap;
        logic                                mirror_h;
        logic                                wram_on;
        logic                                wram_lock;
        logic [CHR_SLOTS-1:0][BANK_W-1:0]    chr_slot;
        logic [PRG_SLOT_W-1:0]               prg_s6;
        logic [PRG_SLOT_W-1:0]               prg_s7;
    } map_state_t;

endpackage

// File: rtl/mapper_cpu_decode.sv
module mapper_cpu_decode
    import mapper_pkg::*;
(
    input  logic [2:0] addr_hi,
    input  logic       addr_lsb,
    input  logic       wr,
    output logic       ptr_wr,
    output logic       data_wr,
    output logic       mir_wr,
    output logic       guard_wr,
    output logic       wram_hit
);

    always_comb begin
        ptr_wr   = 1'b0;
        data_wr  = 1'b0;
        mir_wr   = 1'b0;
        guard_wr = 1'b0;
        wram_hit = 1'b0;
        case (addr_hi)
            RGN_WRAM:   wram_hit = 1'b1;
            RGN_BANK: begin
                ptr_wr  = wr & ~addr_lsb;
                data_wr = wr &  addr_lsb;
            end
            RGN_LAYOUT: begin
                mir_wr   = wr & ~addr_lsb;
                guard_wr = wr &  addr_lsb;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mapper_regs.sv
module mapper_regs
    import mapper_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               ptr_wr,
    input  logic                               data_wr,
    input  logic                               mir_wr,
    input  logic                               guard_wr,
    input  logic [7:0]                         wdata,
    output logic                               prg_swap,
    output logic                               chr_swap,
    output logic                               mirror_h,
    output logic                               wram_on,
    output logic                               wram_lock,
    output logic [CHR_SLOTS-1:0][BANK_W-1:0]   chr_slot,
    output logic [PRG_SLOT_W-1:0]              prg_s6,
    output logic [PRG_SLOT_W-1:0]              prg_s7
);

    map_state_t state_d, state_q;
    logic [BANK_W-1:0] chr_new [CHR_SLOTS];

    // the two 2 KB slots store an even bank number
    for (genvar i = 0; i < CHR_SLOTS; i++) begin : g_slot_fmt
        if (i < 2) begin : g_pair
            assign chr_new[i] = {wdata[BANK_W-1:1], 1'b0};
        end else begin : g_single
            assign chr_new[i] = wdata[BANK_W-1:0];
        end
    end

    always_comb begin
        state_d = state_q;
        if (ptr_wr) begin
            state_d.slot_ptr = wdata[2:0];
            state_d.prg_swap = wdata[6];
            state_d.chr_swap = wdata[7];
        end
        if (data_wr) begin
            case (state_q.slot_ptr)
                3'd0: state_d.chr_slot[0] = chr_new[0];
                3'd1: state_d.chr_slot[1] = chr_new[1];
                3'd2: state_d.chr_slot[2] = chr_new[2];
                3'd3: state_d.chr_slot[3] = chr_new[3];
                3'd4: state_d.chr_slot[4] = chr_new[4];
                3'd5: state_d.chr_slot[5] = chr_new[5];
                3'd6: state_d.prg_s6 = wdata[PRG_SLOT_W-1:0];
                default: state_d.prg_s7 = wdata[PRG_SLOT_W-1:0];
            endcase
        end
        if (mir_wr) begin
            state_d.mirror_h = wdata[0];
        end
        if (guard_wr) begin
            state_d.wram_on   = wdata[7];
            state_d.wram_lock = wdata[6];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign prg_swap  = state_q.prg_swap;
    assign chr_swap  = state_q.chr_swap;
    assign mirror_h  = state_q.mirror_h;
    assign wram_on   = state_q.wram_on;
    assign wram_lock = state_q.wram_lock;
    assign chr_slot  = state_q.chr_slot;
    assign prg_s6    = state_q.prg_s6;
    assign prg_s7    = state_q.prg_s7;

endmodule

// File: rtl/mapper_prg_map.sv
module mapper_prg_map
    import mapper_pkg::*;
#(
    parameter int PRG_BANKS = 64,
    localparam int IDX_W    = $clog2(PRG_BANKS)
) (
    input  logic [14:0]           cpu_addr,
    input  logic                  prg_swap,
    input  logic [PRG_SLOT_W-1:0] prg_s6,
    input  logic [PRG_SLOT_W-1:0] prg_s7,
    output logic [IDX_W+12:0]     prg_addr
);

    localparam logic [IDX_W-1:0] LAST_BANK   = IDX_W'(PRG_BANKS - 1);
    localparam logic [IDX_W-1:0] SECOND_BANK = IDX_W'(PRG_BANKS - 2);

    logic [IDX_W-1:0] bank;

    always_comb begin
        case (cpu_addr[14:13])
            2'd0:    bank = prg_swap ? SECOND_BANK : prg_s6[IDX_W-1:0];
            2'd1:    bank = prg_s7[IDX_W-1:0];
            2'd2:    bank = prg_swap ? prg_s6[IDX_W-1:0] : SECOND_BANK;
            default: bank = LAST_BANK;
        endcase
    end

    assign prg_addr = {bank, cpu_addr[12:0]};

endmodule

// File: rtl/mapper_chr_map.sv
module mapper_chr_map
    import mapper_pkg::*;
(
    input  logic [12:0]                       ppu_addr,
    input  logic                              chr_swap,
    input  logic [CHR_SLOTS-1:0][BANK_W-1:0]  chr_slot,
    output logic [CHR_AW-1:0]                 chr_addr
);

    logic [2:0]        kb;
    logic [BANK_W-1:0] bank;

    always_comb begin
        kb = ppu_addr[12:10] ^ {chr_swap, 2'b00};
        if (!kb[2]) begin
            // 2 KB window: slot is even, address bit 10 fills the low bit
            bank = (kb[1] ? chr_slot[1] : chr_slot[0])
                 | {{(BANK_W-1){1'b0}}, ppu_addr[10]};
        end else begin
            case (kb[1:0])
                2'd0:    bank = chr_slot[2];
                2'd1:    bank = chr_slot[3];
                2'd2:    bank = chr_slot[4];
                default: bank = chr_slot[5];
            endcase
        end
    end

    assign chr_addr = {bank, ppu_addr[9:0]};

endmodule

// File: rtl/pgm_bank_mapper.sv
module pgm_bank_mapper
    import mapper_pkg::*;
#(
    parameter int PRG_BANKS = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [15:0]                    cpu_addr,
    input  logic                           cpu_wr,
    input  logic [7:0]                     cpu_wdata,
    input  logic [12:0]                    ppu_addr,
    output logic [$clog2(PRG_BANKS)+12:0]  prg_addr,
    output logic [CHR_AW-1:0]              chr_addr,
    output logic                           ram_ce,
    output logic                           ram_we,
    output logic                           open_bus,
    output logic                           mirror_horiz
);

    localparam int PRG_IDX_W = $clog2(PRG_BANKS);

    logic ptr_wr, data_wr, mir_wr, guard_wr, wram_hit;
    logic prg_swap, chr_swap, mirror_h, wram_on, wram_lock;
    logic [CHR_SLOTS-1:0][BANK_W-1:0] chr_slot;
    logic [PRG_SLOT_W-1:0] prg_s6, prg_s7;

    mapper_cpu_decode i_decode (
        .addr_hi  (cpu_addr[15:13]),
        .addr_lsb (cpu_addr[0]),
        .wr       (cpu_wr),
        .ptr_wr   (ptr_wr),
        .data_wr  (data_wr),
        .mir_wr   (mir_wr),
        .guard_wr (guard_wr),
        .wram_hit (wram_hit)
    );

    mapper_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_wr    (ptr_wr),
        .data_wr   (data_wr),
        .mir_wr    (mir_wr),
        .guard_wr  (guard_wr),
        .wdata     (cpu_wdata),
        .prg_swap  (prg_swap),
        .chr_swap  (chr_swap),
        .mirror_h  (mirror_h),
        .wram_on   (wram_on),
        .wram_lock (wram_lock),
        .chr_slot  (chr_slot),
        .prg_s6    (prg_s6),
        .prg_s7    (prg_s7)
    );

    mapper_prg_map #(.PRG_BANKS(PRG_BANKS)) i_prg (
        .cpu_addr (cpu_addr[14:0]),
        .prg_swap (prg_swap),
        .prg_s6   (prg_s6),
        .prg_s7   (prg_s7),
        .prg_addr (prg_addr)
    );

    mapper_chr_map i_chr (
        .ppu_addr (ppu_addr),
        .chr_swap (chr_swap),
        .chr_slot (chr_slot),
        .chr_addr (chr_addr)
    );

    assign ram_ce       = wram_hit & wram_on;
    assign open_bus     = wram_hit & ~wram_on;
    assign ram_we       = wram_hit & wram_on & ~wram_lock & cpu_wr;
    assign mirror_horiz = mirror_h;

endmodule

// File: rtl/mapper_chk.sv
module mapper_chk #(
    parameter int PRG_IDX_W = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cpu_wr,
    input logic [2:0]           cpu_hi,
    input logic                 cpu_lsb,
    input logic                 wdata0,
    input logic                 ppu_a12,
    input logic                 ppu_a10,
    input logic                 chr_a10,
    input logic [PRG_IDX_W-1:0] prg_bank,
    input logic                 ram_ce,
    input logic                 ram_we,
    input logic                 open_bus,
    input logic                 mirror_horiz,
    input logic                 chr_inv,
    input logic                 ram_wp,
    input logic [47:0]          chr_banks
);

    // R5
    top_window_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_hi == 3'b111) |-> (prg_bank == {PRG_IDX_W{1'b1}}));

    // R12
    ram_we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (cpu_wr && ram_ce && !ram_wp));

    // R11
    bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_bus |-> (!ram_ce && !ram_we));

    // R9
    pair_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ppu_a12 == chr_inv) |-> (chr_a10 == ppu_a10));

    // R10
    mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_hi == 3'b101 && !cpu_lsb) |=> (mirror_horiz == $past(wdata0)));

    // R13
    upper_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_hi[2:1] == 2'b11) |=>
            ($stable(chr_banks) && $stable(chr_inv) && $stable(mirror_horiz)));

endmodule

bind pgm_bank_mapper mapper_chk #(.PRG_IDX_W(PRG_IDX_W)) i_mapper_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_wr       (cpu_wr),
    .cpu_hi       (cpu_addr[15:13]),
    .cpu_lsb      (cpu_addr[0]),
    .wdata0       (cpu_wdata[0]),
    .ppu_a12      (ppu_addr[12]),
    .ppu_a10      (ppu_addr[10]),
    .chr_a10      (chr_addr[10]),
    .prg_bank     (prg_addr[PRG_IDX_W+12:13]),
    .ram_ce       (ram_ce),
    .ram_we       (ram_we),
    .open_bus     (open_bus),
    .mirror_horiz (mirror_horiz),
    .chr_inv      (chr_swap),
    .ram_wp       (wram_lock),
    .chr_banks    (chr_slot)
);

// File: tb/test_pgm_bank_mapper.sv
`timescale 1ns/1ps
module test_pgm_bank_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = 8'h0;
    logic [12:0] ppu_addr = 13'h0;
    logic [18:0] prg_addr;
    logic [17:0] chr_addr;
    logic        ram_ce, ram_we, open_bus, mirror_horiz;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pgm_bank_mapper i_pgm_bank_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
        .chr_addr(chr_addr), .ram_ce(ram_ce), .ram_we(ram_we),
        .open_bus(open_bus), .mirror_horiz(mirror_horiz)
    );

    // kinds: 0 register write, 1 program check, 2 pattern check,
    //        3 status read check, 4 status write check
    // status value = {ram_we, open_bus, ram_ce, mirror_horiz}
    localparam int NV = 67;
    localparam logic [55:0] VEC [NV] = '{
        {4'd0, 4'd2,  16'h8000, 8'h06, 24'h0},      // R2 pointer -> slot 6
        {4'd0, 4'd2,  16'h8001, 8'h05, 24'h0},
        {4'd1, 4'd3,  16'h8010, 8'h00, 24'h0A010},  // R3
        {4'd1, 4'd3,  16'hC010, 8'h00, 24'h7C010},  // R3
        {4'd0, 4'd2,  16'h8000, 8'h07, 24'h0},
        {4'd0, 4'd2,  16'h8001, 8'h0B, 24'h0},
        {4'd1, 4'd5,  16'hA004, 8'h00, 24'h16004},  // R5
        {4'd1, 4'd5,  16'hE1FF, 8'h00, 24'h7E1FF},  // R5
        {4'd0, 4'd4,  16'h8000, 8'h46, 24'h0},
        {4'd1, 4'd4,  16'h8000, 8'h00, 24'h7C000},  // R4
        {4'd1, 4'd4,  16'hC008, 8'h00, 24'h0A008},  // R4
        {4'd1, 4'd5,  16'hA000, 8'h00, 24'h16000},  // R5
        {4'd0, 4'd6,  16'h8001, 8'hC9, 24'h0},
        {4'd1, 4'd6,  16'hC000, 8'h00, 24'h12000},  // R6
        {4'd0, 4'd6,  16'h8000, 8'h07, 24'h0},
        {4'd0, 4'd6,  16'h8001, 8'hFF, 24'h0},
        {4'd1, 4'd6,  16'hA000, 8'h00, 24'h7E000},  // R6
        {4'd1, 4'd3,  16'h8000, 8'h00, 24'h12000},  // R3
        {4'd0, 4'd7,  16'h8000, 8'h00, 24'h0},
        {4'd0, 4'd9,  16'h8001, 8'h11, 24'h0},
        {4'd0, 4'd2,  16'h8000, 8'h01, 24'h0},
        {4'd0, 4'd2,  16'h8003, 8'h22, 24'h0},      // R2 odd alias
        {4'd0, 4'd2,  16'h8002, 8'h02, 24'h0},      // R2 even alias
        {4'd0, 4'd2,  16'h8001, 8'h30, 24'h0},
        {4'd0, 4'd2,  16'h8000, 8'h03, 24'h0},
        {4'd0, 4'd2,  16'h8001, 8'h31, 24'h0},
        {4'd0, 4'd2,  16'h8000, 8'h04, 24'h0},
        {4'd0, 4'd2,  16'h8001, 8'h32, 24'h0},
        {4'd0, 4'd2,  16'h8000, 8'h05, 24'h0},
        {4'd0, 4'd2,  16'h8001, 8'h33, 24'h0},
        {4'd2, 4'd9,  16'h0000, 8'h00, 24'h04000},  // R9
        {4'd2, 4'd7,  16'h0400, 8'h00, 24'h04400},  // R7
        {4'd2, 4'd7,  16'h0ABC, 8'h00, 24'h08ABC},  // R7
        {4'd2, 4'd7,  16'h0FFF, 8'h00, 24'h08FFF},  // R7
        {4'd2, 4'd7,  16'h1000, 8'h00, 24'h0C000},  // R7
        {4'd2, 4'd7,  16'h1400, 8'h00, 24'h0C400},  // R7
        {4'd2, 4'd7,  16'h1800, 8'h00, 24'h0C800},  // R7
        {4'd2, 4'd7,  16'h1C05, 8'h00, 24'h0CC05},  // R7
        {4'd0, 4'd8,  16'h8000, 8'h80, 24'h0},
        {4'd2, 4'd8,  16'h0000, 8'h00, 24'h0C000},  // R8
        {4'd2, 4'd8,  16'h0C10, 8'h00, 24'h0CC10},  // R8
        {4'd2, 4'd8,  16'h1000, 8'h00, 24'h04000},  // R8
        {4'd2, 4'd8,  16'h1FFF, 8'h00, 24'h08FFF},  // R8
        {4'd0, 4'd9,  16'h8001, 8'h13, 24'h0},
        {4'd2, 4'd9,  16'h1400, 8'h00, 24'h04C00},  // R9
        {4'd2, 4'd9,  16'h1000, 8'h00, 24'h04800},  // R9
        {4'd3, 4'd11, 16'h6000, 8'h00, 24'h4},      // R11
        {4'd0, 4'd10, 16'hA000, 8'h01, 24'h0},
        {4'd3, 4'd10, 16'h7000, 8'h00, 24'h5},      // R10
        {4'd0, 4'd11, 16'hA001, 8'h80, 24'h0},
        {4'd3, 4'd11, 16'h6ABC, 8'h00, 24'h3},      // R11
        {4'd4, 4'd12, 16'h7FFF, 8'h55, 24'hB},      // R12
        {4'd0, 4'd12, 16'hA003, 8'hC0, 24'h0},
        {4'd4, 4'd12, 16'h6000, 8'h55, 24'h3},      // R12
        {4'd0, 4'd10, 16'hA002, 8'h00, 24'h0},
        {4'd3, 4'd10, 16'h6000, 8'h00, 24'h2},      // R10
        {4'd0, 4'd11, 16'hA001, 8'h00, 24'h0},
        {4'd3, 4'd11, 16'h6000, 8'h00, 24'h4},      // R11
        {4'd3, 4'd11, 16'h8000, 8'h00, 24'h0},      // R11
        {4'd4, 4'd13, 16'hC000, 8'h47, 24'h0},      // R13
        {4'd4, 4'd13, 16'hE001, 8'hFF, 24'h0},      // R13
        {4'd4, 4'd13, 16'h5000, 8'hFF, 24'h0},      // R13
        {4'd4, 4'd13, 16'hDFFE, 8'h00, 24'h0},      // R13
        {4'd1, 4'd13, 16'h8000, 8'h00, 24'h12000},  // R13
        {4'd2, 4'd13, 16'h0000, 8'h00, 24'h0C000},  // R13
        {4'd2, 4'd13, 16'h1400, 8'h00, 24'h04C00},  // R13
        {4'd3, 4'd13, 16'h6000, 8'h00, 24'h4}       // R13
    };

    task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    function automatic logic [23:0] status();
        return {20'h0, ram_we, open_bus, ram_ce, mirror_horiz};
    endfunction

    task automatic apply(input logic [55:0] v);
        logic [3:0]  kind;
        logic [3:0]  req;
        logic [15:0] a;
        logic [7:0]  d;
        logic [23:0] exp;
        string tag;
        {kind, req, a, d, exp} = v;
        tag = $sformatf("R%0d addr %h", req, a);
        case (kind)
            4'd0: do_write(a, d);
            4'd1: begin
                @(negedge clk); cpu_wr = 1'b0; cpu_addr = a; #2;
                check(tag, {5'h0, prg_addr}, exp);
            end
            4'd2: begin
                @(negedge clk); cpu_wr = 1'b0; ppu_addr = a[12:0]; #2;
                check(tag, {6'h0, chr_addr}, exp);
            end
            4'd3: begin
                @(negedge clk); cpu_wr = 1'b0; cpu_addr = a; #2;
                check(tag, status(), exp);
            end
            default: begin
                @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; #2;
                check(tag, status(), exp);
                @(negedge clk); cpu_wr = 1'b0;
            end
        endcase
    endtask

    task automatic reset_checks();
        // R1 reset state seen through the mapping outputs
        apply({4'd1, 4'd1, 16'h8000, 8'h00, 24'h00000});
        apply({4'd1, 4'd1, 16'hC000, 8'h00, 24'h7C000});
        apply({4'd1, 4'd1, 16'hA000, 8'h00, 24'h00000});
        apply({4'd2, 4'd1, 16'h0000, 8'h00, 24'h00000});
        apply({4'd2, 4'd1, 16'h1C00, 8'h00, 24'h00000});
        apply({4'd3, 4'd1, 16'h6000, 8'h00, 24'h4});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reset_checks();
        for (int i = 0; i < NV; i++) apply(VEC[i]);
        // second reset after heavy use: state returns to R1
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        reset_checks();
        // pointer reset to slot 0: R2 data write lands in slot 0
        do_write(16'h8001, 8'h08);
        apply({4'd2, 4'd2, 16'h0000, 8'h00, 24'h02000});
        apply({4'd2, 4'd2, 16'h0400, 8'h00, 24'h02400});
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule